// File: doc/BRIEF.md
# Multiframe Marker Generator

This block produces the per-frame multiframe marking for the network-side transmitter of a basic-rate S interface. A frame strobe from the frame serializer advances a frame counter through a multiframe of 20 line frames. In each frame the block reports three things. The first is whether the FA/N bit pair must be sent reversed. The second is the value of the M bit. The third is which of the four bit positions of the 4-bit maintenance word belongs to the current frame. A maintenance sub-channel carries one 4-bit word per multiframe, which gives 800 bit/s per sub-channel.

Marking is allowed by an enable bit. Software writes that bit through a write strobe, and a write counts only while the link is deactivated. Even when marking is allowed, it is applied only while the transmitter sends INFO 2 or INFO 4 frames. A controller state machine has three states:

- `MF_OFF`: marking is disabled.
- `MF_ARMED`: marking is enabled, but the transmitter is not sending a marked INFO state.
- `MF_RUN`: marking is applied.

The transitions are:

- OFF→ARMED on an accepted write of 1.
- ARMED→RUN when the INFO state is 2 or 4.
- RUN→ARMED when the INFO state leaves 2/4.
- ARMED→OFF and RUN→OFF on an accepted write of 0.

A pulse at the end of each multiframe lets the message logic latch words.

Top module: `mf_marker_gen`

## Requirements
- R1: After reset the state is MF_OFF, and `marker_active`, `fa_invert`, `m_bit`, `nibble_load`, `mf_end`, `nibble_sel` and `frame_index` are all 0.
- R2: A write on `cfg_wr` updates the enable only when `link_active` is 0. With `link_active` 1 the write has no effect on any output.
- R3: `info_state` is coded 3'd2 for INFO 2 and 3'd4 for INFO 4. Marking (`marker_active`=1) is present in a cycle only if the previous cycle's `info_state` was one of these codes and the enable was set.
- R4: `frame_index` is 0 in the first cycle of `marker_active`. While marking, a change of `info_state` to 3'd2 from any other code returns `frame_index` to 0 in the following cycle.
- R5: While marking, `frame_strobe` sampled high advances `frame_index` by one in the next cycle, and frame 19 wraps to 0. Without a strobe the index holds.
- R6: `fa_invert` is 1 exactly when marking and `frame_index` is 0, 5, 10 or 15.
- R7: `m_bit` is 1 exactly when marking and `frame_index` is 0.
- R8: `nibble_load` equals `fa_invert`. `nibble_sel` is `frame_index`/5 (0..3) in those frames and 0 otherwise.
- R9: `mf_end` is 1 in a cycle in which `frame_strobe` is high while marking at frame 19, and 0 in every other cycle.
- R10: While the enable is cleared, `fa_invert`, `m_bit`, `nibble_load` and `mf_end` stay 0 whatever `info_state` and `frame_strobe` do.
- R11: When `info_state` leaves the marked codes, marking stops in the next cycle and `frame_index` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe | input | 1 | One-cycle pulse at each line frame boundary |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_enable | input | 1 | Value written to the enable |
| link_active | input | 1 | 1 while the link is activated |
| info_state | input | 3 | Current INFO state code (0..4) |
| fa_invert | output | 1 | Reverse the FA/N bits in this frame |
| m_bit | output | 1 | M bit value for this frame |
| nibble_load | output | 1 | This frame carries a maintenance word bit |
| nibble_sel | output | 2 | Bit position of the 4-bit word for this frame |
| frame_index | output | 5 | Position within the multiframe (0..19) |
| marker_active | output | 1 | Marking is being applied |
| mf_end | output | 1 | Multiframe closes on this strobe |

## Verification
The bench writes the enable while the link is activated and checks that nothing changes. A design that latched such writes would start or stop marking in mid-connection.

It switches INFO 4 back to INFO 2 in the middle of a multiframe. A design without the realignment would keep its old phase and mark the wrong frames.

It sends strobes back to back and across the frame-19 wrap. An off-by-one counter would put the M bit or the end pulse one frame late, or would wrap at 20.

It leaves the marked INFO states and re-enters through INFO 4. A design that kept the stale index would begin a multiframe away from frame 0.

// File: rtl/mfg_pkg.sv
package mfg_pkg;

    localparam int INFO_W = 3;

    localparam logic [INFO_W-1:0] INFO_TWO  = 3'd2;
    localparam logic [INFO_W-1:0] INFO_FOUR = 3'd4;

    typedef enum logic [1:0] {
        MF_OFF   = 2'd0,
        MF_ARMED = 2'd1,
        MF_RUN   = 2'd2
    } mf_state_t;

    function automatic logic is_marked_info(input logic [INFO_W-1:0] code);
        return (code == INFO_TWO) || (code == INFO_FOUR);
    endfunction

endpackage

// File: rtl/mfg_ctrl.sv
module mfg_ctrl
    import mfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              link_active,
    input  logic [INFO_W-1:0] info_state,
    output logic              run,
    output logic              cnt_clear
);

    mf_state_t         state_q;
    mf_state_t         state_d;
    logic [INFO_W-1:0] info_prev_q;
    logic              wr_ok;
    logic              marked;
    logic              info2_edge;

    assign wr_ok      = cfg_wr && !link_active;
    assign marked     = is_marked_info(info_state);
    assign info2_edge = (info_state == INFO_TWO) && (info_prev_q != INFO_TWO);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MF_OFF: begin
                if (wr_ok && cfg_enable) state_d = MF_ARMED;
            end
            MF_ARMED: begin
                if (wr_ok && !cfg_enable) state_d = MF_OFF;
                else if (marked)          state_d = MF_RUN;
            end
            MF_RUN: begin
                if (wr_ok && !cfg_enable) state_d = MF_OFF;
                else if (!marked)         state_d = MF_ARMED;
            end
            default: state_d = MF_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= MF_OFF;
            info_prev_q <= '0;
        end else begin
            state_q     <= state_d;
            info_prev_q <= info_state;
        end
    end

    // outputs
    always_comb begin
        run       = (state_q == MF_RUN);
        cnt_clear = (state_q != MF_RUN) || (state_d != MF_RUN) || info2_edge;
    end

endmodule

// File: rtl/mfg_frame_cnt.sv
module mfg_frame_cnt #(
    parameter int FRAMES = 20,
    localparam int CNT_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] idx,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

    logic [CNT_W-1:0] idx_q;

    assign at_last = (idx_q == LAST);
    assign idx     = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/mfg_marker_dec.sv
module mfg_marker_dec #(
    parameter int FRAMES = 20,
    parameter int PERIOD = 5,
    localparam int CNT_W = $clog2(FRAMES),
    localparam int SLOTS = FRAMES / PERIOD,
    localparam int NIB_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             run,
    input  logic             strobe,
    input  logic             at_last,
    input  logic [CNT_W-1:0] idx,
    output logic             fa_invert,
    output logic             m_bit,
    output logic             nibble_load,
    output logic [NIB_W-1:0] nibble_sel,
    output logic             mf_end
);

    logic [SLOTS-1:0] hit;
    logic [NIB_W-1:0] enc;

    // one compare per marker slot
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign hit[s] = (idx == CNT_W'(s * PERIOD));
    end

    always_comb begin
        enc = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (hit[s]) enc = enc | NIB_W'(s);
        end
    end

    always_comb begin
        fa_invert   = run && (|hit);
        m_bit       = run && hit[0];
        nibble_load = run && (|hit);
        nibble_sel  = (run && (|hit)) ? enc : '0;
        mf_end      = run && strobe && at_last;
    end

endmodule

// File: rtl/mf_marker_gen.sv
module mf_marker_gen
    import mfg_pkg::*;
#(
    parameter int FRAMES = 20,
    parameter int PERIOD = 5,
    localparam int CNT_W = $clog2(FRAMES),
    localparam int SLOTS = FRAMES / PERIOD,
    localparam int NIB_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic              link_active,
    input  logic [INFO_W-1:0] info_state,
    output logic              fa_invert,
    output logic              m_bit,
    output logic              nibble_load,
    output logic [NIB_W-1:0]  nibble_sel,
    output logic [CNT_W-1:0]  frame_index,
    output logic              marker_active,
    output logic              mf_end
);

    logic run;
    logic cnt_clear;
    logic at_last;

    mfg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_enable (cfg_enable),
        .link_active(link_active),
        .info_state (info_state),
        .run        (run),
        .cnt_clear  (cnt_clear)
    );

    mfg_frame_cnt #(.FRAMES(FRAMES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .advance(run && frame_strobe),
        .idx    (frame_index),
        .at_last(at_last)
    );

    mfg_marker_dec #(.FRAMES(FRAMES), .PERIOD(PERIOD)) u_dec (
        .run        (run),
        .strobe     (frame_strobe),
        .at_last    (at_last),
        .idx        (frame_index),
        .fa_invert  (fa_invert),
        .m_bit      (m_bit),
        .nibble_load(nibble_load),
        .nibble_sel (nibble_sel),
        .mf_end     (mf_end)
    );

    assign marker_active = run;

endmodule

// File: rtl/mf_marker_gen_chk.sv
module mf_marker_gen_chk
    import mfg_pkg::*;
#(
    parameter int FRAMES = 20,
    parameter int CNT_W  = 5,
    parameter int NIB_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe,
    input logic              cfg_wr,
    input logic              cfg_enable,
    input logic              link_active,
    input logic [INFO_W-1:0] info_state,
    input logic              fa_invert,
    input logic              m_bit,
    input logic              nibble_load,
    input logic [NIB_W-1:0]  nibble_sel,
    input logic [CNT_W-1:0]  frame_index,
    input logic              marker_active,
    input logic              mf_end
);

    // R7: the M frame is always also a reversal frame
    p_m_in_fa_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_bit |-> fa_invert);

    // R10: nothing is marked while marking is off
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !marker_active |-> (!fa_invert && !m_bit && !nibble_load && !mf_end));

    // R3: leaving the marked INFO codes stops marking next cycle
    p_info_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((info_state == INFO_TWO) || (info_state == INFO_FOUR)) |=> !marker_active);

    // R4: a marking run begins at frame 0
    p_entry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(marker_active) |-> (frame_index == '0));

    // R5: the frame after a multiframe end is frame 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |=> (frame_index == '0));

    // R5: without a strobe or INFO change the index holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_active && !frame_strobe && (info_state == INFO_FOUR)
         && !(cfg_wr && !link_active && !cfg_enable))
        |=> $stable(frame_index));

    // R9: the end pulse never lasts two cycles
    p_mfend_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |=> !mf_end);

    // R9: the end pulse only comes with a strobe at the last frame
    p_mfend_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |-> (frame_strobe && frame_index == CNT_W'(FRAMES - 1)));

    // R8: the position is 0 outside the word-carrying frames
    p_nibble_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nibble_load |-> (nibble_sel == '0));

    // R8: the load flag follows the reversal flag
    p_load_fa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nibble_load == fa_invert);

    // R2: a write while activated cannot turn marking off
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_active && link_active && cfg_wr && (info_state == INFO_FOUR))
        |=> marker_active);

endmodule

bind mf_marker_gen mf_marker_gen_chk #(
    .FRAMES(FRAMES),
    .CNT_W (CNT_W),
    .NIB_W (NIB_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .cfg_wr       (cfg_wr),
    .cfg_enable   (cfg_enable),
    .link_active  (link_active),
    .info_state   (info_state),
    .fa_invert    (fa_invert),
    .m_bit        (m_bit),
    .nibble_load  (nibble_load),
    .nibble_sel   (nibble_sel),
    .frame_index  (frame_index),
    .marker_active(marker_active),
    .mf_end       (mf_end)
);

// File: tb/mf_marker_gen_tb.sv
`timescale 1ns/1ps
module mf_marker_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       link_active = 1'b0;
    logic [2:0] info_state = 3'd0;
    logic       fa_invert, m_bit, nibble_load, marker_active, mf_end;
    logic [1:0] nibble_sel;
    logic [4:0] frame_index;

    int checks = 0;
    int errors = 0;

    // behavioural reference: 0 = off, 1 = enabled idle, 2 = marking
    int mode = 0;
    int fidx = 0;
    int pinfo = 0;

    always #2 clk = ~clk;

    mf_marker_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .cfg_wr       (cfg_wr),
        .cfg_enable   (cfg_enable),
        .link_active  (link_active),
        .info_state   (info_state),
        .fa_invert    (fa_invert),
        .m_bit        (m_bit),
        .nibble_load  (nibble_load),
        .nibble_sel   (nibble_sel),
        .frame_index  (frame_index),
        .marker_active(marker_active),
        .mf_end       (mf_end)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit on;
        on = (mode == 2);
        chk("R3", "marker_active", int'(marker_active), int'(on));
        chk("R5", "frame_index", int'(frame_index), fidx);
        chk("R6", "fa_invert", int'(fa_invert), int'(on && (fidx % 5 == 0)));
        chk("R7", "m_bit", int'(m_bit), int'(on && fidx == 0));
        chk("R8", "nibble_load", int'(nibble_load), int'(on && (fidx % 5 == 0)));
        chk("R8", "nibble_sel", int'(nibble_sel), (on && (fidx % 5 == 0)) ? fidx / 5 : 0);
        chk("R9", "mf_end", int'(mf_end), int'(on && frame_strobe && fidx == 19));
    endtask

    task automatic model_update();
        bit accepted, marked;
        int nmode;
        accepted = cfg_wr && !link_active;
        marked = (info_state == 3'd2) || (info_state == 3'd4);
        nmode = mode;
        if (accepted && !cfg_enable) nmode = 0;
        else if (mode == 0 && accepted && cfg_enable) nmode = 1;
        else if (mode == 1 && marked) nmode = 2;
        else if (mode == 2 && !marked) nmode = 1;
        if (nmode != 2 || mode != 2) fidx = 0;
        else if (info_state == 3'd2 && pinfo != 2) fidx = 0;
        else if (frame_strobe) fidx = (fidx + 1) % 20;
        mode = nmode;
        pinfo = int'(info_state);
    endtask

    task automatic step(input bit st, input bit wr, input bit val, input bit act, input int inf);
        @(negedge clk);
        frame_strobe = st;
        cfg_wr = wr;
        cfg_enable = val;
        link_active = act;
        info_state = 3'(inf);
        #1;
        compare_all();
        model_update();
    endtask

    // run n frames, strobe every gap cycles
    task automatic frames(input int n, input int gap, input bit act, input int inf);
        for (int f = 0; f < n; f++) begin
            for (int g = 1; g < gap; g++) step(0, 0, 0, act, inf);
            step(1, 0, 0, act, inf);
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "marker_active", int'(marker_active), 0);
        chk("R1", "frame_index", int'(frame_index), 0);
        chk("R1", "fa_invert/m_bit/mf_end", int'({fa_invert, m_bit, mf_end, nibble_load}), 0);
        compare_all();

        // R10: not enabled, marked INFO with strobes: nothing
        frames(6, 2, 0, 2);
        chk("R10", "fa_invert while disabled", int'(fa_invert), 0);
        chk("R10", "m_bit while disabled", int'(m_bit), 0);

        // R2: enable write while activated is ignored
        step(0, 1, 1, 1, 4);
        frames(3, 2, 1, 4);
        chk("R2", "marker_active after locked write", int'(marker_active), 0);

        // accepted enable with INFO 0, then enter INFO 2
        step(0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R3", "no marking in INFO 0", int'(marker_active), 0);
        step(0, 0, 0, 0, 2);
        step(0, 0, 0, 0, 2);
        chk("R4", "entry frame index", int'(frame_index), 0);
        chk("R4", "entry marking", int'(marker_active), 1);

        // R5/R9: two full multiframes, spaced then back-to-back strobes
        frames(25, 3, 0, 2);
        frames(30, 1, 0, 2);

        // INFO 4, then back to INFO 2 mid multiframe: R4 realign
        frames(7, 2, 1, 4);
        step(0, 0, 0, 1, 2);
        step(0, 0, 0, 1, 2);
        chk("R4", "realign on INFO 2 entry", int'(frame_index), 0);
        frames(23, 2, 1, 2);

        // R11: leave marked codes
        step(0, 0, 0, 1, 3);
        step(0, 0, 0, 1, 3);
        chk("R11", "marking stopped", int'(marker_active), 0);
        chk("R11", "index cleared", int'(frame_index), 0);
        frames(4, 2, 1, 3);

        // re-enter through INFO 4, run past a wrap
        frames(22, 2, 1, 4);

        // R2: disable write while activated is ignored
        step(0, 1, 0, 1, 4);
        step(0, 0, 0, 1, 4);
        chk("R2", "still marking after locked disable", int'(marker_active), 1);
        frames(5, 2, 1, 4);

        // R10: disable while deactivated, then strobes in INFO 4
        step(0, 1, 0, 0, 4);
        frames(8, 2, 0, 4);
        chk("R10", "off after accepted disable", int'(marker_active), 0);
        chk("R10", "mf_end quiet", int'(mf_end), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule